// File: doc/BRIEF.md
# Eye Scan Sweep Sequencer

This block walks a receiver's secondary (offset) comparator across a two-dimensional grid of phase and voltage offsets. At each grid point it compares every valid secondary sample with the matching main data sample. It counts the mismatches over a programmable window and hands the 16-bit error count to a host through a byte-wide register port, high byte first. The analog comparator, the management bus physical layer and the lock/adaptation logic lie outside the block. Each sample pair arrives as two single-bit inputs with a valid strobe.

Host reads pace the sweep:

- **MSB read.** Accepting a read of the high byte moves the comparator to the next grid point and restarts counting at once.
- **Held result.** A finished count is held back until both bytes of the result in hand have been read.
- **Unlimited stream.** Because of this interlock, the host may read as slowly as it likes and never loses a point.

Both access styles work against one internal byte pointer:

- **Byte pairs.** The host reads address 0x25 and then 0x26 for each point.
- **Streaming.** The host reads 0x25 repeatedly and gets high, low, high, low in turn. It may pause between bytes at any time and resume later.

The read port is a valid/ready handshake. The host raises `rd_valid` with `rd_addr` and holds both until `rd_ready` is high at a clock edge. `rd_ready` drops only in one case: a sweep is running, the addressed byte is a high byte, and its result is not yet complete. This is the only back-pressure in the block. Read data comes back one cycle after acceptance with a single-cycle `rd_dvalid`, and it cannot be stalled. Writes are always accepted.

Top module: `eyescan_seq`

## Requirements
- R1: After reset the offsets are 0, `sweep_done` is 0, `mon_pwr_on` is 0, `range_code` is 0, `rd_dvalid` is 0, and register 0x11 reads 0x20.
- R2: Register 0x11 reads back as written. `range_code` equals its bits 7:6, with codes 0..3 meaning ±100/±200/±300/±400 mV. `mon_pwr_on` is the inverse of its bit 5, which is an active-low power-down. Register 0x2a (window code) reads back as written.
- R3: A sweep runs only while all four conditions hold: 0x24 bit 7 (enable) is 1, 0x24 bit 1 (start) is 1, 0x22 bit 7 (override) is 0, and 0x11 bit 5 is 0. When none runs, the offsets do not move and reads of 0x25 are never stalled. If any condition drops during a sweep, the sweep aborts. When all four hold again, the sweep restarts at point 0.
- R4: The window for each point is (W+1)·2^WIN_SHIFT valid samples, where W is the value of 0x2a. The result is the number of valid samples in that window whose secondary bit differs from the main bit. Samples without `smp_valid` are not counted.
- R5: The error count saturates at 0xFFFF.
- R6: Points run in order with phase as the inner loop and voltage as the outer loop. Phase steps 0..2^PH_BITS−1 for each voltage value, and voltage steps 0..2^VT_BITS−1.
- R7: Accepting a high-byte read of a complete result advances the offsets on that same clock edge and restarts counting. No other event except the start of a sweep changes the offsets.
- R8: While sweeping, a high-byte read is stalled (`rd_ready`=0) until the current point's count is complete. A count that finishes before the previous result's low byte has been read is held and does not replace it.
- R9: A read of 0x25 returns the high byte when no high byte of the current result is outstanding, and the low byte otherwise. A read of 0x26 always returns the low byte. Pauses between reads do not disturb this order.
- R10: Reading the low byte of the last point ends the sweep. `sweep_done` goes to 1, 0x24 reads {enable,00000,start=0,done=1}, and the offsets stay at the last point. A write with 0x24 bit 1 set clears done.
- R11: Every accepted read gives `rd_dvalid`=1 with its data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this edge when high |
| rd_addr | input | 8 | Read address, held with `rd_valid` |
| rd_data | output | 8 | Read data, valid with `rd_dvalid` |
| rd_dvalid | output | 1 | Read data strobe, one cycle after acceptance |
| smp_valid | input | 1 | Sample pair valid |
| smp_main | input | 1 | Main comparator decision |
| smp_sec | input | 1 | Secondary comparator decision |
| phase_ofs | output | PH_BITS | Current phase offset |
| volt_ofs | output | VT_BITS | Current voltage offset |
| range_code | output | 2 | Secondary comparator voltage range code |
| mon_pwr_on | output | 1 | Monitor power enable |
| sweep_done | output | 1 | Sweep complete flag |

## Verification
The hardest case to reach is a count that completes while the previous result's low byte is still unread. That count must be held rather than loaded. The bench gets there by reading a high byte and then idling for longer than the largest window before it reads the low byte. It then checks that the low byte still belongs to the earlier point and that the next high byte carries the later point's count. Each grid point's mismatch behaviour is picked at random from the phase and voltage offsets the block drives. This lets every returned count be predicted exactly even with random gaps in `smp_valid`. Saturation needs a window longer than 65535 samples, so it runs on a second instance at default sizes.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;
  localparam logic [7:0] A_CFG = 8'h11;
  localparam logic [7:0] A_OVR = 8'h22;
  localparam logic [7:0] A_CTL = 8'h24;
  localparam logic [7:0] A_HI  = 8'h25;
  localparam logic [7:0] A_LO  = 8'h26;
  localparam logic [7:0] A_WIN = 8'h2A;
  localparam int RES_W = 16;
endpackage

// File: rtl/eyescan_regs.sv
module eyescan_regs import eyescan_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       fin_set,
  output logic [7:0] cfg,
  output logic       ovr,
  output logic       ctl_en,
  output logic       ctl_start,
  output logic       done,
  output logic [7:0] win
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= 8'h20;
      ovr       <= 1'b0;
      ctl_en    <= 1'b0;
      ctl_start <= 1'b0;
      done      <= 1'b0;
      win       <= 8'h00;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CFG: cfg <= wr_data;
          A_OVR: ovr <= wr_data[7];
          A_CTL: begin
            ctl_en    <= wr_data[7];
            ctl_start <= wr_data[1];
            if (wr_data[1]) done <= 1'b0;
          end
          A_WIN: win <= wr_data;
          default: ;
        endcase
      end
      if (fin_set) begin
        ctl_start <= 1'b0;
        done      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eyescan_accum.sv
module eyescan_accum import eyescan_pkg::*; #(
  parameter int WIN_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [7:0]       win,
  input  logic             smp_valid,
  input  logic             mism,
  output logic [RES_W-1:0] err,
  output logic             fin
);
  localparam int CW = 9 + WIN_SHIFT;
  localparam logic [RES_W-1:0] ERR_MAX = '1;

  logic [CW-1:0] cnt, tgt;
  logic          act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tgt <= '0;
      act <= 1'b0;
      err <= '0;
      fin <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      err <= '0;
      act <= 1'b1;
      fin <= 1'b0;
      tgt <= ({{(CW-8){1'b0}}, win} + CW'(1)) << WIN_SHIFT;
    end else if (act && smp_valid) begin
      cnt <= cnt + CW'(1);
      if (mism && err != ERR_MAX) err <= err + RES_W'(1);
      if (cnt + CW'(1) == tgt) begin
        act <= 1'b0;
        fin <= 1'b1;
      end
    end
  end

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err == ERR_MAX && !restart) |=> err == ERR_MAX);
  assert_skip_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !smp_valid) |=> $stable(err));
endmodule

// File: rtl/eyescan_grid.sv
module eyescan_grid #(
  parameter int PH_BITS = 6,
  parameter int VT_BITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  output logic [PH_BITS-1:0] phase,
  output logic [VT_BITS-1:0] volt,
  output logic               last
);
  localparam int PW = PH_BITS + VT_BITS;
  logic [PW-1:0] point;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     point <= '0;
    else if (clear) point <= '0;
    else if (step)  point <= point + PW'(1);
  end

  assign phase = point[PH_BITS-1:0];
  assign volt  = point[PW-1:PH_BITS];
  assign last  = &point;
endmodule

// File: rtl/eyescan_seq.sv
module eyescan_seq import eyescan_pkg::*; #(
  parameter int PH_BITS   = 6,
  parameter int VT_BITS   = 6,
  parameter int WIN_SHIFT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [7:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic               rd_dvalid,
  input  logic               smp_valid,
  input  logic               smp_main,
  input  logic               smp_sec,
  output logic [PH_BITS-1:0] phase_ofs,
  output logic [VT_BITS-1:0] volt_ofs,
  output logic [1:0]         range_code,
  output logic               mon_pwr_on,
  output logic               sweep_done
);
  logic [7:0]       cfg, win;
  logic             ovr, ctl_en, ctl_start;
  logic [RES_W-1:0] acc_err, res_q;
  logic             acc_fin, grid_last;
  logic             sweeping, pend, res_full, msb_taken;
  logic             run, sweep_go, sweep_stop, restart, step, finish;
  logic             hi_slot, lo_slot, acc, msb_acc, lsb_acc, load;
  logic [7:0]       rd_mux;

  assign run        = ctl_en & ctl_start & ~ovr & ~cfg[5];
  assign sweep_go   = run & ~sweeping;
  assign sweep_stop = sweeping & ~run;

  assign hi_slot  = (rd_addr == A_HI) & ~msb_taken;
  assign lo_slot  = (rd_addr == A_LO) | ((rd_addr == A_HI) & msb_taken);
  assign rd_ready = ~(sweeping & hi_slot & ~res_full);
  assign acc      = rd_valid & rd_ready;
  assign msb_acc  = acc & hi_slot & sweeping & res_full;
  assign lsb_acc  = acc & lo_slot & msb_taken;
  assign step     = msb_acc & ~grid_last;
  assign restart  = sweep_go | step;
  assign finish   = lsb_acc & grid_last & ~pend & sweeping;
  assign load     = sweeping & pend & acc_fin & ~res_full;

  eyescan_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .fin_set(finish), .cfg, .ovr, .ctl_en, .ctl_start,
    .done(sweep_done), .win
  );

  eyescan_accum #(.WIN_SHIFT(WIN_SHIFT)) u_accum (
    .clk, .rst_n, .restart, .win, .smp_valid,
    .mism(smp_main ^ smp_sec), .err(acc_err), .fin(acc_fin)
  );

  eyescan_grid #(.PH_BITS(PH_BITS), .VT_BITS(VT_BITS)) u_grid (
    .clk, .rst_n, .clear(sweep_go), .step,
    .phase(phase_ofs), .volt(volt_ofs), .last(grid_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweeping  <= 1'b0;
      pend      <= 1'b0;
      res_full  <= 1'b0;
      msb_taken <= 1'b0;
      res_q     <= '0;
    end else if (sweep_go) begin
      sweeping  <= 1'b1;
      pend      <= 1'b1;
      res_full  <= 1'b0;
      msb_taken <= 1'b0;
    end else if (sweep_stop) begin
      sweeping  <= 1'b0;
      pend      <= 1'b0;
      res_full  <= 1'b0;
      msb_taken <= 1'b0;
    end else begin
      if (load) begin
        res_q    <= acc_err;
        res_full <= 1'b1;
        pend     <= 1'b0;
      end
      if (msb_acc) begin
        msb_taken <= 1'b1;
        if (step) pend <= 1'b1;
      end
      if (lsb_acc) begin
        msb_taken <= 1'b0;
        res_full  <= 1'b0;
      end
      if (finish) sweeping <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_mux = cfg;
      A_OVR:   rd_mux = {ovr, 7'b0};
      A_CTL:   rd_mux = {ctl_en, 5'b0, ctl_start, sweep_done};
      A_WIN:   rd_mux = win;
      A_HI:    rd_mux = msb_taken ? res_q[7:0] : res_q[15:8];
      A_LO:    rd_mux = res_q[7:0];
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_dvalid <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      rd_dvalid <= acc;
      if (acc) rd_data <= rd_mux;
    end
  end

  assign range_code = cfg[7:6];
  assign mon_pwr_on = ~cfg[5];

  assert_offsets_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(phase_ofs) && $stable(volt_ofs)));
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_full && !lsb_acc && !sweep_go && !sweep_stop) |=> ($stable(res_q) && res_full));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> !sweeping);
  assert_data_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_dvalid);
endmodule

// File: tb/eyescan_seq_test.sv
module eyescan_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       wr_en_s = 0, wr_en_b = 0, rv_s = 0, rv_b = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic       s_valid = 0, s_main = 0, s_sec = 0;
  logic       rdy_s, rdy_b, dv_s, dv_b, done_s, done_b, pwr_s, pwr_b;
  logic [7:0] dat_s, dat_b;
  logic [1:0] ph_s, vt_s, rng_s, rng_b;
  logic [5:0] ph_b, vt_b;
  bit         bad [16];
  int         nchk = 0, nerr = 0, cyc = 0;

  eyescan_seq #(.PH_BITS(2), .VT_BITS(2), .WIN_SHIFT(3)) uut (
    .clk, .rst_n, .wr_en(wr_en_s), .wr_addr, .wr_data,
    .rd_valid(rv_s), .rd_ready(rdy_s), .rd_addr, .rd_data(dat_s), .rd_dvalid(dv_s),
    .smp_valid(s_valid), .smp_main(s_main), .smp_sec(s_sec),
    .phase_ofs(ph_s), .volt_ofs(vt_s), .range_code(rng_s),
    .mon_pwr_on(pwr_s), .sweep_done(done_s));

  eyescan_seq uut_big (
    .clk, .rst_n, .wr_en(wr_en_b), .wr_addr, .wr_data,
    .rd_valid(rv_b), .rd_ready(rdy_b), .rd_addr, .rd_data(dat_b), .rd_dvalid(dv_b),
    .smp_valid(1'b1), .smp_main(1'b0), .smp_sec(1'b1),
    .phase_ofs(ph_b), .volt_ofs(vt_b), .range_code(rng_b),
    .mon_pwr_on(pwr_b), .sweep_done(done_b));

  always @(negedge clk) begin : drive_samples
    bit m;
    m = 1'($urandom);
    s_valid = ($urandom % 4) != 0;
    s_main  = m;
    s_sec   = m ^ bad[{vt_s, ph_s}];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit big, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d;
    if (big) wr_en_b = 1; else wr_en_s = 1;
    @(negedge clk);
    wr_en_b = 0; wr_en_s = 0;
  endtask

  task automatic rd(input bit big, input logic [7:0] a, output logic [7:0] d, output int stalls);
    @(negedge clk);
    rd_addr = a;
    if (big) rv_b = 1; else rv_s = 1;
    stalls = 0;
    #1;
    while (!(big ? rdy_b : rdy_s)) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    rv_b = 0; rv_s = 0;
    d = big ? dat_b : dat_s;
    chk((big ? dv_b : dv_s) == 1'b1, "R11 data strobe", 0, 1);
  endtask

  function automatic int exp_count(input int k, input int w);
    return bad[k] ? (w + 1) * 8 : 0;
  endfunction

  task automatic new_bad();
    for (int i = 0; i < 16; i++) bad[i] = ($urandom % 2) != 0;
  endtask

  task automatic sweep_reads(input int w);
    logic [7:0] hi, lo;
    int st;
    for (int k = 0; k < 16; k++) begin
      rd(0, 8'h25, hi, st);
      if (k == 0) chk(st > 0, "R8 first high byte stalls", st, 1);
      if (k < 15) begin
        chk(ph_s == 2'((k + 1) % 4), "R6 phase inner order", ph_s, (k + 1) % 4);
        chk(vt_s == 2'((k + 1) / 4), "R7 step after high byte", vt_s, (k + 1) / 4);
      end
      if ($urandom % 3 == 0) repeat (90) @(negedge clk);
      if ($urandom % 2 == 0) rd(0, 8'h26, lo, st);
      else rd(0, 8'h25, lo, st);
      chk({hi, lo} == 16'(exp_count(k, w)), "R4 R8 R9 point result", {hi, lo}, exp_count(k, w));
    end
    @(negedge clk);
    chk(done_s == 1'b1, "R10 done pin", done_s, 1);
    rd(0, 8'h24, hi, st);
    chk(hi == 8'h81, "R10 control readback", hi, 8'h81);
    chk(ph_s == 2'd3 && vt_s == 2'd3, "R10 offsets stay at last", {vt_s, ph_s}, 4'hF);
  endtask

  initial begin
    logic [7:0] d, d2;
    int st, w1, w2;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ph_s == 0 && vt_s == 0, "R1 offsets", {vt_s, ph_s}, 0);
    chk(done_s == 0 && dv_s == 0, "R1 done/strobe", {done_s, dv_s}, 0);
    chk(pwr_s == 0 && rng_s == 0, "R1 power/range", {pwr_s, rng_s}, 0);
    rd(0, 8'h11, d, st);
    chk(d == 8'h20, "R1 cfg reset", d, 8'h20);

    wr(0, 8'h11, 8'hC0);
    @(negedge clk);
    chk(rng_s == 2'd3 && pwr_s == 1, "R2 range/power pins", {pwr_s, rng_s}, 3'b111);
    rd(0, 8'h11, d, st);
    chk(d == 8'hC0, "R2 cfg readback", d, 8'hC0);
    w1 = int'($urandom % 4);
    wr(0, 8'h2A, 8'(w1));
    rd(0, 8'h2A, d, st);
    chk(d == 8'(w1), "R2 window readback", d, w1);
    wr(0, 8'h11, 8'h80);

    new_bad();
    wr(0, 8'h24, 8'h82);
    sweep_reads(w1);

    wr(0, 8'h22, 8'h80);
    new_bad();
    w2 = int'($urandom % 4);
    wr(0, 8'h2A, 8'(w2));
    wr(0, 8'h24, 8'h82);
    chk(done_s == 0, "R10 start clears done", done_s, 0);
    repeat (30) @(negedge clk);
    chk(ph_s == 3 && vt_s == 3, "R3 override blocks sweep", {vt_s, ph_s}, 4'hF);
    rd(0, 8'h25, d, st);
    chk(st == 0, "R3 idle read not stalled", st, 0);
    wr(0, 8'h22, 8'h00);
    repeat (2) @(negedge clk);
    chk(ph_s == 0 && vt_s == 0, "R3 sweep starts at point 0", {vt_s, ph_s}, 0);
    wr(0, 8'h11, 8'hA0);
    repeat (2) @(negedge clk);
    chk(pwr_s == 0, "R2 power pin off", pwr_s, 0);
    rd(0, 8'h25, d, st);
    chk(st == 0, "R3 power-down aborts sweep", st, 0);
    wr(0, 8'h11, 8'h80);
    sweep_reads(w2);

    wr(1, 8'h11, 8'h00);
    wr(1, 8'h2A, 8'h3F);
    wr(1, 8'h24, 8'h82);
    rd(1, 8'h25, d, st);
    chk(st > 65000, "R4 long window stall", st, 65536);
    rd(1, 8'h26, d2, st);
    chk({d, d2} == 16'hFFFF, "R5 saturation", {d, d2}, 16'hFFFF);
    chk(ph_b == 6'd1 && vt_b == 6'd0, "R6 default grid step", {vt_b, ph_b}, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule